// File: doc/BRIEF.md
# Configurable UART Character Framer

This block is the transmit side of an asynchronous serial character. It takes one parallel word through a valid/ready load port and shifts it out on a single serial line. The character is framed as a low start bit, five to eight data bits sent least significant bit first, an optional control bit, and one or two high stop bits. The line rests high between characters.

The control bit has four uses, chosen by a 2-bit mode and a type bit. It can carry computed even or odd parity, a forced constant level, or an address/data marker for multidrop links, or it can be left out of the frame. An external baud-tick enable sets the pace, and every serial bit lasts a fixed number of ticks. All framing options are captured when a word is loaded, so the mode inputs may change freely while a character is being sent. A new word may be loaded in the cycle right after the previous character ends, which gives gapless streaming.

Top module: `uart_char_framer`

## Requirements
- R1: Out of reset, and whenever no character is in progress, `txd` is 1 and `ld_ready` is 1.
- R2: A load (`ld_valid` and `ld_ready` high at a clock edge) drives `txd` to 0 for the start bit from the next cycle. Data bits follow least significant bit first, and each serial bit lasts TICKS_PER_BIT (default 16) `baud_tick` pulses.
- R3: `cfg_len` sets the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Word bits above the selected length are never sent.
- R4: When `cfg_pmode` is 00, the control bit is parity over the selected data bits only. `cfg_ptype` 0 gives even parity (the XOR of the data bits) and 1 gives odd parity (its inverse).
- R5: When `cfg_pmode` is 01, the control bit is the constant `cfg_ptype`: 0 sends low and 1 sends high.
- R6: When `cfg_pmode` is 10, no control bit is sent, and `cfg_ptype` has no effect on the frame.
- R7: When `cfg_pmode` is 11 (multidrop), the control bit equals `cfg_ptype`: 1 marks an address and 0 marks data.
- R8: After the data and control bits come one high stop bit when `cfg_two_stop` is 0, or two when it is 1.
- R9: Data and all `cfg_*` inputs are captured at the load edge. Changing them afterwards does not alter the character in progress.
- R10: `ld_ready` is 0 from the cycle after a load until the `baud_tick` that ends the last stop bit. A load offered in the following cycle starts a new start bit with no idle gap.
- R11: While a character is in progress, `txd` and `ld_ready` change only at an edge where `baud_tick` is high, except at the load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Oversampling pacing enable |
| ld_valid | input | 1 | Load request |
| ld_ready | output | 1 | Framer idle, load accepted |
| ld_data | input | 8 | Word to send |
| cfg_pmode | input | 2 | Control-bit mode: 00 parity, 01 forced, 10 none, 11 multidrop |
| cfg_ptype | input | 1 | Parity type, forced level or address flag |
| cfg_len | input | 2 | Data length code (5 to 8 bits) |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| txd | output | 1 | Serial line, idles high |

## Verification
Words are sent in all four control-bit modes with both type values, so each mode is separated from the others. Every length code is used with words whose unused upper bits are set, which shows whether masking applies to the parity and to the shifted bits. The pacing runs at one tick per cycle and at one tick per three cycles, and loads are offered back to back, which tests the tick counting and the gapless handover. After each accepted load the mode inputs and data are scrambled, so any setting read after the load edge shows up as a wrong bit.

// File: rtl/uart_char_framer.sv
module uart_char_framer #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       ld_valid,
  output logic       ld_ready,
  input  logic [7:0] ld_data,
  input  logic [1:0] cfg_pmode,
  input  logic       cfg_ptype,
  input  logic [1:0] cfg_len,
  input  logic       cfg_two_stop,
  output logic       txd
);
  localparam int TCW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [TCW-1:0] TLAST = TCW'(TICKS_PER_BIT - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_CTRL, S_STOP1, S_STOP2} st_t;

  st_t            st;
  logic [TCW-1:0] tcnt;
  logic [2:0]     bidx, blast;
  logic [7:0]     sh;
  logic           ctrl_q, has_ctrl_q, two_q;

  wire       load    = ld_valid && ld_ready;
  wire       bit_end = baud_tick && (tcnt == TLAST);
  wire [7:0] mask    = 8'hFF >> (2'd3 - cfg_len);
  wire       par     = ^(ld_data & mask);
  wire       ctrl_d  = (cfg_pmode == 2'b00) ? (par ^ cfg_ptype) : cfg_ptype;

  assign ld_ready = (st == S_IDLE);

  always_comb begin
    case (st)
      S_START: txd = 1'b0;
      S_DATA:  txd = sh[0];
      S_CTRL:  txd = ctrl_q;
      default: txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      tcnt       <= '0;
      bidx       <= '0;
      blast      <= '0;
      sh         <= '0;
      ctrl_q     <= 1'b0;
      has_ctrl_q <= 1'b0;
      two_q      <= 1'b0;
    end else if (load) begin
      st         <= S_START;
      tcnt       <= '0;
      bidx       <= '0;
      blast      <= 3'd4 + {1'b0, cfg_len};
      sh         <= ld_data;
      ctrl_q     <= ctrl_d;
      has_ctrl_q <= (cfg_pmode != 2'b10);
      two_q      <= cfg_two_stop;
    end else if (st != S_IDLE && baud_tick) begin
      tcnt <= bit_end ? '0 : tcnt + 1'b1;
      if (bit_end) begin
        case (st)
          S_START: st <= S_DATA;
          S_DATA: begin
            sh <= sh >> 1;
            if (bidx == blast) st <= has_ctrl_q ? S_CTRL : S_STOP1;
            else               bidx <= bidx + 1'b1;
          end
          S_CTRL:  st <= S_STOP1;
          S_STOP1: st <= two_q ? S_STOP2 : S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_char_framer_chk.sv
module uart_char_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic ld_valid,
  input logic ld_ready,
  input logic txd
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready |-> txd); // R1

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready) |=> (!txd && !ld_ready)); // R2

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_tick && !(ld_valid && ld_ready)) |=> ($stable(txd) && $stable(ld_ready))); // R11

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_ready && !baud_tick) |=> !ld_ready); // R10

  AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_ready && baud_tick && !txd) |=> !ld_ready); // R8
endmodule

bind uart_char_framer uart_char_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
  .ld_valid(ld_valid), .ld_ready(ld_ready), .txd(txd)
);

// File: tb/uart_char_framer_tb.sv
module uart_char_framer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TPB = 16;

  logic clk = 0, rst_n = 0, baud_tick = 0, ld_valid = 0;
  logic ld_ready, txd;
  logic [7:0] ld_data = 0;
  logic [1:0] cfg_pmode = 0, cfg_len = 0;
  logic cfg_ptype = 0, cfg_two_stop = 0;

  uart_char_framer #(.TICKS_PER_BIT(TPB)) u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .ld_data(ld_data), .cfg_pmode(cfg_pmode),
    .cfg_ptype(cfg_ptype), .cfg_len(cfg_len), .cfg_two_stop(cfg_two_stop), .txd(txd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [11:0] b; int n; int nd; int has_c; string ctag; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_bad = 0, tick_div = 1, tick_cnt = 0;
  bit mon_busy = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    tick_cnt <= (tick_cnt + 1 >= tick_div) ? 0 : tick_cnt + 1;
    baud_tick <= (tick_cnt == 0);
  end

  task automatic send(input logic [7:0] d, input logic [1:0] pm, input logic pt,
                      input logic [1:0] ln, input logic two);
    exp_t e;
    int nd;
    logic c;
    nd = 5 + ln;
    c = 0;
    for (int i = 0; i < nd; i++) c = c ^ d[i];
    c = (pm == 2'b00) ? (c ^ pt) : pt;
    e.b = '0; e.n = 0; e.nd = nd; e.has_c = (pm != 2'b10);
    e.ctag = (pm == 2'b00) ? "R4" : (pm == 2'b01) ? "R5" : (pm == 2'b11) ? "R7" : "R6";
    e.b[e.n++] = 1'b0;
    for (int i = 0; i < nd; i++) e.b[e.n++] = d[i];
    if (pm != 2'b10) e.b[e.n++] = c;
    e.b[e.n++] = 1'b1;
    if (two) e.b[e.n++] = 1'b1;
    q.push_back(e);
    ld_data = d; cfg_pmode = pm; cfg_ptype = pt; cfg_len = ln; cfg_two_stop = two;
    ld_valid = 1;
    forever begin
      @(posedge clk);
      if (ld_ready) break;
    end
    @(negedge clk);
    ld_valid = 0;
    ld_data = 8'($urandom); cfg_pmode = 2'($urandom); cfg_ptype = 1'($urandom);
    cfg_len = 2'($urandom); cfg_two_stop = 1'($urandom);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && ld_valid && ld_ready) begin
        exp_t e;
        int n, k;
        logic tk;
        string tag;
        mon_busy = 1;
        e = q.pop_front();
        n = 0;
        @(negedge clk);
        while (n < TPB * e.n) begin
          @(posedge clk); tk = baud_tick;
          @(negedge clk);
          if (tk) begin
            n++;
            if (n % TPB == TPB/2) begin
              k = n / TPB;
              if (k == 0) tag = "R2 R11 start";
              else if (k <= e.nd) tag = "R2 R3 R9 data";
              else if (e.has_c != 0 && k == e.nd + 1) tag = {e.ctag, " R9 control"};
              else tag = "R8 R6 stop";
              check(txd === e.b[k], tag, int'(txd), int'(e.b[k]));
              check(ld_ready === 1'b0, "R10 busy", int'(ld_ready), 0);
            end
          end
        end
        check(ld_ready === 1'b1 && txd === 1'b1, "R10 R1 release", int'(ld_ready), 1);
        mon_busy = 0;
      end
    end
  end

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(txd === 1'b1, "R1 reset txd", int'(txd), 1);
    check(ld_ready === 1'b1, "R1 reset ready", int'(ld_ready), 1);
    rst_n = 1;
    @(negedge clk);
    tick_div = 1;
    send(8'hA5, 2'b00, 1'b0, 2'b11, 1'b0);
    send(8'hA5, 2'b00, 1'b1, 2'b11, 1'b1);
    send(8'hF3, 2'b00, 1'b0, 2'b00, 1'b0);
    send(8'hEC, 2'b00, 1'b1, 2'b01, 1'b0);
    send(8'hD5, 2'b01, 1'b0, 2'b10, 1'b0);
    send(8'h55, 2'b01, 1'b1, 2'b10, 1'b1);
    tick_div = 3;
    send(8'h81, 2'b10, 1'b1, 2'b11, 1'b0);
    send(8'h81, 2'b10, 1'b0, 2'b11, 1'b1);
    send(8'h3A, 2'b11, 1'b1, 2'b11, 1'b0);
    send(8'h3A, 2'b11, 1'b0, 2'b11, 1'b0);
    send(8'hFE, 2'b00, 1'b1, 2'b00, 1'b1);
    while (q.size() != 0 || mon_busy) @(negedge clk);
    repeat (5) @(negedge clk);
    check(txd === 1'b1 && ld_ready === 1'b1, "R1 final idle", int'(txd), 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule